// File: doc/BRIEF.md
# Pad Loopback Scan Sequencer

This block runs a self-test over a row of I/O pads through per-pad output and input scan cells. After a start pulse it visits the pads one at a time in ascending index order, unbonded positions included. Each visited pad is taken through three drive phases. In the first it drives a 1 with the output enabled. In the second the output is released. In the third it drives a 0 with the output enabled. After each phase the block waits a programmable number of settle clocks. It then captures the pad's returning value in that pad's input cell and compares it with the expected level.

Each pad has a select bit that picks where its input cell listens. One source is the direct pad receiver. The other is the reference/differential comparator output. A pad whose capture ever disagrees with the expected level gets a sticky fail flag, and the sweep always carries on to the final pad. A busy level covers the whole sweep, and a single-cycle done pulse closes it. The pad's analog behaviour outside the block is treated as a plain loopback with a weak keeper.

Top module: `bscan_loop_tester`

## Requirements
- R1: After synchronous reset, busy_o, done_o, every fail_o bit and every pad_oe_o bit are 0.
- R2: A start_i pulse while idle begins a sweep and latches settle_cycles_i. A start_i pulse during a sweep, or a change of settle_cycles_i during a sweep, has no effect on the sweep length or on the fail flags.
- R3: Pads are visited in ascending index order. Each pad's output takes the codes {pad_oe_o,pad_out_o} = 2'b11 (high), then 2'b00 (released), then 2'b10 (low), then 2'b00 again before the next pad starts, so both levels and the released state appear on every pad.
- R4: In the released phase the expected readback is the PULL_VAL parameter (default 1). A pad that keeps driving 0 when released is flagged.
- R5: With latched settle count S, the input cell samples on the (S+2)-th rising edge after the edge that updated the output cell.
- R6: path_sel_i[i]=0 compares the direct input pad_in_i[i]. path_sel_i[i]=1 compares the comparator input ref_in_i[i]. A fault on the unselected source is ignored.
- R7: Any mismatch sets fail_o[i] for that pad and it stays set until the next accepted start, which clears all flags. The sweep still runs to the last pad, and the flags hold after done.
- R8: busy_o is high for exactly 3*NUM_PADS*(S+4) cycles after the start edge. done_o is then high for one cycle with busy_o low.
- R9: At most one pad has its output enabled at any time, and no output is enabled while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| settle_cycles_i | input | SETTLE_W | Settle count S, latched at start |
| path_sel_i | input | NUM_PADS | Per-pad source select: 0 direct, 1 comparator |
| pad_in_i | input | NUM_PADS | Direct pad receiver values |
| ref_in_i | input | NUM_PADS | Reference/differential comparator outputs |
| pad_oe_o | output | NUM_PADS | Output-enable from each output cell |
| pad_out_o | output | NUM_PADS | Drive value from each output cell |
| fail_o | output | NUM_PADS | Sticky per-pad fail flags |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench feeds the sweep through a loopback with a three-clock delay. A settle count of 1 must then fail every pad on its low phase, and a count of 2 must pass every pad, which pins the capture edge. Stuck-at-0 and stuck-at-1 faults on the direct path show whether the high or the low phase catches each fault. Crossing comparator-path faults with a mixed select pattern separates a working source mux from one that ignores the select. A pad that never releases its output isolates the released-phase check against the keeper level. Extra start pulses and a changed settle value in mid-sweep must leave the sweep length and the flags untouched.

// File: rtl/bslt_pkg.sv
package bslt_pkg;

    typedef enum logic [1:0] {
        STEP_HIGH = 2'd0,
        STEP_REL  = 2'd1,
        STEP_LOW  = 2'd2
    } drive_step_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRIVE,
        SQ_SETTLE,
        SQ_CAPTURE,
        SQ_JUDGE,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drive_t;

    function automatic pad_drive_t drive_for(drive_step_e s);
        pad_drive_t d;
        case (s)
            STEP_HIGH: d = '{oe: 1'b1, val: 1'b1};
            STEP_LOW:  d = '{oe: 1'b1, val: 1'b0};
            default:   d = '{oe: 1'b0, val: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic expect_for(drive_step_e s, logic pull);
        case (s)
            STEP_HIGH: return 1'b1;
            STEP_REL:  return pull;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic drive_step_e step_after(drive_step_e s);
        case (s)
            STEP_HIGH: return STEP_REL;
            STEP_REL:  return STEP_LOW;
            default:   return STEP_HIGH;
        endcase
    endfunction

endpackage

// File: rtl/bslt_out_cell.sv
module bslt_out_cell
    import bslt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_i,
    input  logic       rel_i,
    input  pad_drive_t drive_i,
    output logic       oe_o,
    output logic       out_o
);
    pad_drive_t cell_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= '{oe: 1'b0, val: 1'b0};
        end else if (upd_i) begin
            cell_q <= drive_i;
        end else if (rel_i) begin
            cell_q <= '{oe: 1'b0, val: 1'b0};
        end
    end

    assign oe_o  = cell_q.oe;
    assign out_o = cell_q.val;
endmodule

// File: rtl/bslt_in_cell.sv
module bslt_in_cell (
    input  logic clk,
    input  logic rst,
    input  logic cap_i,
    input  logic path_sel_i,
    input  logic pad_i,
    input  logic ref_i,
    output logic q_o
);
    logic src;
    logic q;

    always_comb src = path_sel_i ? ref_i : pad_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (cap_i) begin
            q <= src;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/bslt_seq.sv
module bslt_seq
    import bslt_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int SETTLE_W = 8,
    localparam int IDX_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic [IDX_W-1:0]    pad_idx_o,
    output drive_step_e         step_o,
    output logic                upd_o,
    output logic                cap_o,
    output logic                judge_o,
    output logic                rel_o,
    output logic                clr_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PADS - 1);

    seq_state_e          state_q;
    logic [IDX_W-1:0]    idx_q;
    drive_step_e         step_q;
    logic [SETTLE_W-1:0] cnt_q;
    logic [SETTLE_W-1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            idx_q    <= '0;
            step_q   <= STEP_HIGH;
            cnt_q    <= '0;
            settle_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        state_q  <= SQ_DRIVE;
                        idx_q    <= '0;
                        step_q   <= STEP_HIGH;
                        settle_q <= settle_i;
                    end
                end
                SQ_DRIVE: begin
                    cnt_q   <= settle_q;
                    state_q <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_CAPTURE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_CAPTURE: state_q <= SQ_JUDGE;
                SQ_JUDGE: begin
                    if (step_q == STEP_LOW) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= SQ_FINISH;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            step_q  <= STEP_HIGH;
                            state_q <= SQ_DRIVE;
                        end
                    end else begin
                        step_q  <= step_after(step_q);
                        state_q <= SQ_DRIVE;
                    end
                end
                SQ_FINISH: state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    assign pad_idx_o = idx_q;
    assign step_o    = step_q;
    assign upd_o     = (state_q == SQ_DRIVE);
    assign cap_o     = (state_q == SQ_CAPTURE);
    assign judge_o   = (state_q == SQ_JUDGE);
    assign rel_o     = (state_q == SQ_JUDGE) && (step_q == STEP_LOW);
    assign clr_o     = (state_q == SQ_IDLE) && start_i;
    assign busy_o    = (state_q != SQ_IDLE) && (state_q != SQ_FINISH);
    assign done_o    = (state_q == SQ_FINISH);
endmodule

// File: rtl/bslt_judge.sv
module bslt_judge
    import bslt_pkg::*;
#(
    parameter int   NUM_PADS = 8,
    parameter logic PULL_VAL = 1'b1,
    localparam int  IDX_W    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                judge_i,
    input  logic [IDX_W-1:0]    pad_idx_i,
    input  drive_step_e         step_i,
    input  logic [NUM_PADS-1:0] cap_i,
    output logic [NUM_PADS-1:0] fail_o
);
    logic [NUM_PADS-1:0] fail_q;
    logic                miss;

    always_comb miss = (cap_i[pad_idx_i] != expect_for(step_i, PULL_VAL));

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                fail_q[i] <= 1'b0;
            end else if (judge_i && miss && (pad_idx_i == IDX_W'(i))) begin
                fail_q[i] <= 1'b1;
            end
        end
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/bscan_loop_tester.sv
module bscan_loop_tester
    import bslt_pkg::*;
#(
    parameter int   NUM_PADS = 8,
    parameter int   SETTLE_W = 8,
    parameter logic PULL_VAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic [NUM_PADS-1:0] path_sel_i,
    input  logic [NUM_PADS-1:0] pad_in_i,
    input  logic [NUM_PADS-1:0] ref_in_i,
    output logic [NUM_PADS-1:0] pad_oe_o,
    output logic [NUM_PADS-1:0] pad_out_o,
    output logic [NUM_PADS-1:0] fail_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

    logic [IDX_W-1:0]    pad_idx;
    drive_step_e         step;
    logic                upd, cap, judge, rel, clr;
    logic [NUM_PADS-1:0] cap_vec;
    pad_drive_t          drive;

    always_comb drive = drive_for(step);

    bslt_seq #(
        .NUM_PADS (NUM_PADS),
        .SETTLE_W (SETTLE_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .settle_i  (settle_cycles_i),
        .pad_idx_o (pad_idx),
        .step_o    (step),
        .upd_o     (upd),
        .cap_o     (cap),
        .judge_o   (judge),
        .rel_o     (rel),
        .clr_o     (clr),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        logic hit;
        assign hit = (pad_idx == IDX_W'(i));

        bslt_out_cell out_i (
            .clk     (clk),
            .rst     (rst),
            .upd_i   (upd && hit),
            .rel_i   (rel && hit),
            .drive_i (drive),
            .oe_o    (pad_oe_o[i]),
            .out_o   (pad_out_o[i])
        );

        bslt_in_cell in_i (
            .clk        (clk),
            .rst        (rst),
            .cap_i      (cap && hit),
            .path_sel_i (path_sel_i[i]),
            .pad_i      (pad_in_i[i]),
            .ref_i      (ref_in_i[i]),
            .q_o        (cap_vec[i])
        );
    end

    bslt_judge #(
        .NUM_PADS (NUM_PADS),
        .PULL_VAL (PULL_VAL)
    ) judge_i (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .judge_i   (judge),
        .pad_idx_i (pad_idx),
        .step_i    (step),
        .cap_i     (cap_vec),
        .fail_o    (fail_o)
    );
endmodule

// File: rtl/bscan_loop_tester_chk.sv
module bscan_loop_tester_chk #(
    parameter int NUM_PADS = 8,
    parameter int SETTLE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [SETTLE_W-1:0] settle_cycles_i,
    input logic [NUM_PADS-1:0] pad_oe_o,
    input logic [NUM_PADS-1:0] fail_o,
    input logic                busy_o,
    input logic                done_o
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && fail_o == '0 && pad_oe_o == '0));

    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ((fail_o & $past(fail_o)) == $past(fail_o)));

    a_r7_flags_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o) && !$past(start_i) && !$past(rst)) |-> $stable(fail_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_one_driver: assert property (@(posedge clk) disable iff (rst)
        $countones(pad_oe_o) <= 1);

    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (pad_oe_o == '0));
endmodule

bind bscan_loop_tester bscan_loop_tester_chk #(
    .NUM_PADS (NUM_PADS),
    .SETTLE_W (SETTLE_W)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .settle_cycles_i (settle_cycles_i),
    .pad_oe_o        (pad_oe_o),
    .fail_o          (fail_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
);

// File: tb/bscan_loop_tester_tb_top.sv
module bscan_loop_tester_tb_top;
    localparam int   N     = 8;
    localparam int   SW    = 8;
    localparam logic PULL  = 1'b1;
    localparam int   DELAY = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic [N-1:0]  path_sel = '0;
    logic [N-1:0]  pad_in, ref_in;
    logic [N-1:0]  pad_oe, pad_out, fail;
    logic          busy, done;

    logic [N-1:0] f_stuck0 = '0, f_stuck1 = '0, f_ref0 = '0, f_keep = '0;
    logic [N-1:0] dline [DELAY];
    logic [N-1:0] loop_val;

    int checks = 0;
    int failures = 0;
    int runs_done = 0;

    always #10 clk = ~clk;

    bscan_loop_tester #(.NUM_PADS(N), .SETTLE_W(SW), .PULL_VAL(PULL)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .settle_cycles_i(settle_i),
        .path_sel_i(path_sel), .pad_in_i(pad_in), .ref_in_i(ref_in),
        .pad_oe_o(pad_oe), .pad_out_o(pad_out), .fail_o(fail),
        .busy_o(busy), .done_o(done)
    );

    // loopback pad model with a fixed propagation delay
    always_comb
        for (int i = 0; i < N; i++)
            loop_val[i] = (pad_oe[i] || f_keep[i]) ? pad_out[i] : PULL;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DELAY; k++) dline[k] <= {N{PULL}};
        end else begin
            dline[0] <= loop_val;
            for (int k = 1; k < DELAY; k++) dline[k] <= dline[k-1];
        end
    end

    assign pad_in = (dline[DELAY-1] | f_stuck1) & ~f_stuck0;
    assign ref_in = dline[DELAY-1] & ~f_ref0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [N-1:0] fail;
        int           busy_cycles;
        string        req;
    } exp_t;
    exp_t sb_q[$];

    // scoreboard monitor
    int           busy_cnt = 0;
    int           prog [N];
    logic [1:0]   prev_code [N];
    int           order_err = 0;
    int           next_pad = 0;
    bit           done_prev = 0;
    logic [1:0]   seq_codes [4] = '{2'b11, 2'b00, 2'b10, 2'b00};

    initial for (int i = 0; i < N; i++) begin prog[i] = 0; prev_code[i] = 2'b00; end

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                logic [1:0] c;
                c = {pad_oe[i], pad_out[i]};
                if (c != prev_code[i]) begin
                    if (prog[i] >= 4 || c != seq_codes[prog[i]]) order_err++;
                    else begin
                        if (prog[i] == 0) begin
                            if (i != next_pad) order_err++;
                            next_pad++;
                        end
                        prog[i]++;
                    end
                    prev_code[i] = c;
                end
            end
            if (busy) busy_cnt++;
            if (done_prev)
                check(!done, "R8", "done lasts one cycle", done, 0);
            if (done) begin
                bit all_prog;
                all_prog = 1;
                for (int i = 0; i < N; i++) if (prog[i] != 4) all_prog = 0;
                check(!busy, "R8", "busy low with done", busy, 0);
                if (sb_q.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(fail == e.fail, e.req, "fail flags", fail, e.fail);
                    check(busy_cnt == e.busy_cycles, "R8", "busy length", busy_cnt, e.busy_cycles);
                    check(order_err == 0 && all_prog && next_pad == N, "R3",
                          "pad/phase order", order_err, 0);
                    check(pad_oe == '0, "R9", "outputs released at done", pad_oe, 0);
                end
                busy_cnt = 0; order_err = 0; next_pad = 0;
                for (int i = 0; i < N; i++) prog[i] = 0;
                runs_done++;
            end
            done_prev = done;
        end
    end

    // driver: computes the expectation from the requirements and starts a sweep
    task automatic run_case(input int s, input string req, input bit disturb);
        exp_t e;
        int target;
        bit short_settle;
        short_settle = (s + 2) < (DELAY + 1);
        for (int i = 0; i < N; i++) begin
            if (short_settle) e.fail[i] = 1'b1;
            else e.fail[i] = f_keep[i] |
                (path_sel[i] ? f_ref0[i] : (f_stuck0[i] | f_stuck1[i]));
        end
        e.busy_cycles = 3 * N * (s + 4);
        e.req = req;
        sb_q.push_back(e);
        target = runs_done + 1;
        @(negedge clk);
        settle_i = SW'(s);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            repeat (37) @(negedge clk);
            start_i = 1'b1; settle_i = '0;
            @(negedge clk);
            start_i = 1'b0;
            repeat (50) @(negedge clk);
            start_i = 1'b1; settle_i = 8'd9;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (runs_done < target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(fail == '0, "R1", "fail after reset", fail, 0);
        check(pad_oe == '0, "R1", "oe after reset", pad_oe, 0);

        // clean sweep at the settle boundary that just passes (R5)
        run_case(2, "R5", 0);
        // short settle: low phase reads the stale keeper level on every pad (R5)
        run_case(1, "R5", 0);
        // stuck faults on the direct path, sweep continues past them (R7)
        f_stuck0 = 8'h02; f_stuck1 = 8'h40;
        run_case(2, "R7", 0);
        // flags held after done (R7)
        repeat (20) @(negedge clk);
        check(fail == 8'h42, "R7", "flags held after done", fail, 8'h42);
        // source mux: direct faults on 1,2, comparator faults on 3,4 (R6)
        f_stuck0 = 8'h06; f_stuck1 = '0; f_ref0 = 8'h18; path_sel = 8'hAA;
        run_case(2, "R6", 0);
        // released phase readback against keeper level (R4)
        f_stuck0 = '0; f_ref0 = '0; path_sel = '0; f_keep = 8'h20;
        run_case(3, "R4", 0);
        // start and settle changes mid-sweep ignored; flags cleared by new start (R2)
        f_keep = '0;
        run_case(2, "R2", 1);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule